// File: doc/BRIEF.md
# One-Time-Programmable Word Controller

This block sits in front of a word-organized one-time-programmable array and turns single requests into safe accesses to it. The array is modelled as a bank of 32-bit words. A request is a word read, a bit-level program, or a factory load that overwrites a whole word. Reads and factory loads address the array by byte offset. Program requests address it by word index.

A program request carries an active-low selection mask, where a 0 marks a bit to burn. The controller fetches the current word and decides whether the request is allowed. It then writes back the merged word, in a direction set by the parity of the word index. Even words can only gain 1 bits and odd words can only lose them. The response reports completion, an error flag, the resulting word, and a vector of the selected bits that were already burned. Only one request is in flight at a time. Every request takes the same fixed number of cycles.

Top module: `otp_word_ctrl`

## Requirements
- R1: `req_ready` is high whenever no request is in flight. A request is taken at a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low in the cycle after that edge. `resp_done` is high for exactly one cycle, the cycle after the second rising edge counted from acceptance, and `req_ready` is high again in that cycle.
- R2: After reset, every even word holds 0x00000000 and every odd word holds 0xFFFFFFFF. `resp_done`, `resp_err`, `resp_rdata` and `resp_preprog` are 0, and `req_ready` is 1.
- R3: A read (`req_op` = 0) of an aligned byte offset whose four bytes lie inside the array returns word `offset/4` in `resp_rdata`, with `resp_err` = 0 and `resp_preprog` = 0.
- R4: A read or factory load whose offset is not a multiple of 4, or whose offset + 4 exceeds 4*WORDS, ends with `resp_err` = 1, `resp_rdata` = 0 and no change to the array.
- R5: A program (`req_op` = 1) of an even word index writes `current | ~mask` and returns that value in `resp_rdata` with `resp_err` = 0.
- R6: A program of an odd word index writes `current & mask`, so only the 0-marked bits are cleared. The new value is returned in `resp_rdata` with `resp_err` = 0.
- R7: A program whose current word equals `~mask` is refused. The response has `resp_err` = 1 and `resp_rdata` = current word, and the word is left unchanged.
- R8: For every in-range program, `resp_preprog` marks the selected bits already in their burned state. On even words these are selected bits that are 1; on odd words they are selected bits that are 0. These flags alone never cause an error. For reads, factory loads and errored requests outside the array, `resp_preprog` is 0.
- R9: A program whose word index is WORDS or higher ends with `resp_err` = 1, `resp_rdata` = 0 and no change to the array.
- R10: A factory load (`req_op` = 2) inside the array overwrites the whole word with `req_wdata` in either bit direction. It returns `req_wdata` in `resp_rdata` with `resp_err` = 0.
- R11: A program write never moves a bit toward its unburned state. It never clears a bit of an even word and never sets a bit of an odd word.
- R12: The reserved operation code 3 ends with `resp_err` = 1, `resp_rdata` = 0 and no change to the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_op | input | 2 | 0 read, 1 program, 2 factory load, 3 reserved |
| req_addr | input | ADDR_W | Word index for program, byte offset otherwise |
| req_mask | input | 32 | Active-low burn selection for program |
| req_wdata | input | 32 | Word value for factory load |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Request failed (valid with resp_done) |
| resp_rdata | output | 32 | Read word, resulting word, or loaded word |
| resp_preprog | output | 32 | Selected bits already burned (program only) |

## Verification
The bound checker checks the handshake timing on every cycle: a taken request drops ready, the busy cycle is always followed by one done pulse, and done never lasts two cycles. It also checks at every program write that even words only gain bits and odd words only lose them, and that an errored response was never preceded by a write. The values themselves only show up in the bench scenarios, which a behavioural word model predicts. These values are the merge results, the refusal rule, the already-burned flags, the byte and index bounds at the array end, and the contents surviving refused requests.

// File: rtl/otp_ctrl_pkg.sv
package otp_ctrl_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    OPC_READ = 2'd0,
    OPC_BURN = 2'd1,
    OPC_LOAD = 2'd2,
    OPC_NONE = 2'd3
  } otp_opc_e;

  typedef struct packed {
    logic              err;
    logic [WORD_W-1:0] rdata;
    logic [WORD_W-1:0] preprog;
  } otp_resp_t;

  // Merged word for a burn: even words gain the selected bits, odd words lose them.
  function automatic logic [WORD_W-1:0] burn_merge(input logic [WORD_W-1:0] cur,
                                                   input logic [WORD_W-1:0] sel_n,
                                                   input logic              odd);
    return odd ? (cur & sel_n) : (cur | ~sel_n);
  endfunction

  // Selected bits that already sit in their burned state.
  function automatic logic [WORD_W-1:0] burn_already(input logic [WORD_W-1:0] cur,
                                                     input logic [WORD_W-1:0] sel_n,
                                                     input logic              odd);
    return odd ? (~cur & ~sel_n) : (cur & ~sel_n);
  endfunction

  // Refusal rule: the word already equals the inverted mask.
  function automatic logic burn_refused(input logic [WORD_W-1:0] cur,
                                        input logic [WORD_W-1:0] sel_n);
    return cur == ~sel_n;
  endfunction

  // True when a four-byte access at byte offset off lies fully inside the array.
  function automatic logic span_fits(input logic [31:0] off, input int unsigned bytes);
    return (off[1:0] == 2'b00) && ((off + 32'd4) <= 32'(bytes));
  endfunction

endpackage

// File: rtl/otp_req_check.sv
module otp_req_check
  import otp_ctrl_pkg::*;
#(
  parameter int WORDS  = 64,
  parameter int ADDR_W = 12,
  localparam int IW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  output logic [IW-1:0]     word_idx,
  output logic              out_of_range
);

  localparam int unsigned ARRAY_BYTES = WORDS * 4;

  logic [31:0] addr32;
  logic [31:0] byte_word;

  always_comb begin
    addr32    = 32'(addr);
    byte_word = addr32 >> 2;
    unique case (otp_opc_e'(op))
      OPC_BURN: begin
        word_idx     = addr32[IW-1:0];
        out_of_range = addr32 >= 32'(WORDS);
      end
      OPC_READ, OPC_LOAD: begin
        word_idx     = byte_word[IW-1:0];
        out_of_range = !span_fits(addr32, ARRAY_BYTES);
      end
      default: begin
        word_idx     = '0;
        out_of_range = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/otp_burn_merge.sv
module otp_burn_merge
  import otp_ctrl_pkg::*;
(
  input  logic [WORD_W-1:0] cur,
  input  logic [WORD_W-1:0] sel_n,
  input  logic              odd,
  output logic [WORD_W-1:0] merged,
  output logic [WORD_W-1:0] already,
  output logic              refused
);

  always_comb begin
    merged  = burn_merge(cur, sel_n, odd);
    already = burn_already(cur, sel_n, odd);
    refused = burn_refused(cur, sel_n);
  end

endmodule

// File: rtl/otp_word_array.sv
module otp_word_array
  import otp_ctrl_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IW-1:0]     ridx,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] cells [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_cell
    localparam logic [WORD_W-1:0] BLANK = (g % 2 == 1) ? '1 : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cells[g] <= BLANK;
      else if (we && (32'(widx) == g))
        cells[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < WORDS; i++)
      if (32'(ridx) == i) rdata = cells[i];
  end

endmodule

// File: rtl/otp_word_ctrl.sv
module otp_word_ctrl
  import otp_ctrl_pkg::*;
#(
  parameter int WORDS  = 64,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_mask,
  input  logic [31:0]       req_wdata,
  output logic              resp_done,
  output logic              resp_err,
  output logic [31:0]       resp_rdata,
  output logic [31:0]       resp_preprog
);

  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;

  // Held request
  logic              busy;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       mask_q;
  logic [31:0]       wdata_q;

  // Named internal events
  logic              accept;
  logic [IW-1:0]     word_idx;
  logic              out_of_range;
  logic [31:0]       cur_word;
  logic [31:0]       merged;
  logic [31:0]       already;
  logic              refused;
  logic              is_burn;
  logic              is_load;
  logic              wr_en;
  logic              wr_burn;
  logic              wr_odd;
  logic [31:0]       wr_old;
  logic [31:0]       wr_new;
  otp_resp_t         resp_next;
  otp_resp_t         resp_q;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      op_q    <= '0;
      addr_q  <= '0;
      mask_q  <= '1;
      wdata_q <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      op_q    <= req_op;
      addr_q  <= req_addr;
      mask_q  <= req_mask;
      wdata_q <= req_wdata;
    end else begin
      busy    <= 1'b0;
    end
  end

  otp_req_check #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_check (
    .op           (op_q),
    .addr         (addr_q),
    .word_idx     (word_idx),
    .out_of_range (out_of_range)
  );

  otp_burn_merge u_merge (
    .cur     (cur_word),
    .sel_n   (mask_q),
    .odd     (word_idx[0]),
    .merged  (merged),
    .already (already),
    .refused (refused)
  );

  always_comb begin
    is_burn = otp_opc_e'(op_q) == OPC_BURN;
    is_load = otp_opc_e'(op_q) == OPC_LOAD;
    wr_burn = is_burn;
    wr_odd  = word_idx[0];
    wr_old  = cur_word;
    wr_en   = busy && !out_of_range && ((is_burn && !refused) || is_load);
    wr_new  = is_burn ? merged : wdata_q;
  end

  otp_word_array #(.WORDS(WORDS)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .widx  (word_idx),
    .wdata (wr_new),
    .ridx  (word_idx),
    .rdata (cur_word)
  );

  always_comb begin
    resp_next.err     = out_of_range || (is_burn && refused);
    resp_next.preprog = '0;
    if (out_of_range)
      resp_next.rdata = '0;
    else if (is_burn)
      resp_next.rdata = refused ? cur_word : merged;
    else if (is_load)
      resp_next.rdata = wdata_q;
    else
      resp_next.rdata = cur_word;
    if (is_burn && !out_of_range)
      resp_next.preprog = already;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_done <= 1'b0;
      resp_q    <= '0;
    end else begin
      resp_done <= busy;
      if (busy) resp_q <= resp_next;
    end
  end

  assign resp_err     = resp_q.err;
  assign resp_rdata   = resp_q.rdata;
  assign resp_preprog = resp_q.preprog;

endmodule

// File: rtl/otp_word_ctrl_chk.sv
module otp_word_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        req_ready,
  input logic        busy,
  input logic        resp_done,
  input logic        resp_err,
  input logic        wr_en,
  input logic        wr_burn,
  input logic        wr_odd,
  input logic [31:0] wr_old,
  input logic [31:0] wr_new
);

  p_accept_locks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !req_ready));

  p_busy_then_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> resp_done);

  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done);

  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> req_ready);

  p_even_sets_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_burn && !wr_odd) |-> ((wr_old & ~wr_new) == 32'h0));

  p_odd_clears_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_burn && wr_odd) |-> ((~wr_old & wr_new) == 32'h0));

  p_err_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done && resp_err) |-> $past(!wr_en));

endmodule

bind otp_word_ctrl otp_word_ctrl_chk u_otp_word_ctrl_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .req_ready (req_ready),
  .busy      (busy),
  .resp_done (resp_done),
  .resp_err  (resp_err),
  .wr_en     (wr_en),
  .wr_burn   (wr_burn),
  .wr_odd    (wr_odd),
  .wr_old    (wr_old),
  .wr_new    (wr_new)
);

// File: tb/test_otp_word_ctrl.sv
`timescale 1ns/1ps
module test_otp_word_ctrl;

  localparam int WORDS  = 64;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [1:0]        req_op = 2'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_mask = '1;
  logic [31:0]       req_wdata = '0;
  logic              resp_done;
  logic              resp_err;
  logic [31:0]       resp_rdata;
  logic [31:0]       resp_preprog;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [WORDS];

  always #2 clk = ~clk;

  otp_word_ctrl #(.WORDS(WORDS), .ADDR_W(ADDR_W)) i_otp_word_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_mask(req_mask), .req_wdata(req_wdata),
    .resp_done(resp_done), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .resp_preprog(resp_preprog)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference: walk the bits one by one.
  function automatic logic [31:0] ref_burn(input logic [31:0] cur, input logic [31:0] m, input bit odd);
    logic [31:0] r = cur;
    for (int i = 0; i < 32; i++) if (m[i] == 1'b0) r[i] = odd ? 1'b0 : 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] ref_flags(input logic [31:0] cur, input logic [31:0] m, input bit odd);
    logic [31:0] f = '0;
    for (int i = 0; i < 32; i++) if (m[i] == 1'b0 && cur[i] == (odd ? 1'b0 : 1'b1)) f[i] = 1'b1;
    return f;
  endfunction

  task automatic do_op(input int op, input int addr, input logic [31:0] m, input logic [31:0] d);
    logic        e_err;
    logic [31:0] e_rd, e_pre, cur;
    string       tag;
    int          w;
    bit          odd;
    e_err = 1'b0; e_rd = '0; e_pre = '0; tag = "R12"; w = -1; odd = 0;
    if (op == 1) begin
      if (addr >= WORDS) begin e_err = 1; tag = "R9"; end
      else begin
        cur = model[addr]; odd = addr[0];
        e_pre = ref_flags(cur, m, odd);
        if (cur == ~m) begin e_err = 1; e_rd = cur; tag = "R7"; end
        else begin
          e_rd = ref_burn(cur, m, odd); w = addr;
          tag = odd ? "R6" : "R5";
          // R11: no bit moves back toward the unburned state
          chk("R11", odd ? (~cur & e_rd) : (cur & ~e_rd), 32'h0);
        end
      end
    end else if (op == 0 || op == 2) begin
      if ((addr % 4) != 0 || addr + 4 > 4 * WORDS) begin e_err = 1; tag = "R4"; end
      else if (op == 0) begin e_rd = model[addr / 4]; tag = "R3"; end
      else begin e_rd = d; w = addr / 4; tag = "R10"; end
    end else begin
      e_err = 1;
    end
    @(negedge clk);
    chk("R1 ready idle", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_op = op[1:0]; req_addr = addr[ADDR_W-1:0]; req_mask = m; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 ready busy", {30'b0, req_ready, resp_done}, 32'd0);
    @(negedge clk);
    chk("R1 done", {31'b0, resp_done}, 32'd1);
    chk("R1 ready at done", {31'b0, req_ready}, 32'd1);
    chk({tag, " err"}, {31'b0, resp_err}, {31'b0, e_err});
    chk({tag, " rdata"}, resp_rdata, e_rd);
    chk("R8 preprog", resp_preprog, e_pre);
    if (w >= 0) model[w] = (op == 1) ? e_rd : d;
    @(negedge clk);
    chk("R1 single done", {31'b0, resp_done}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) model[i] = (i % 2 == 1) ? 32'hFFFF_FFFF : 32'h0;
    repeat (3) @(negedge clk);
    // R2: reset state at the ports
    chk("R2 ready", {31'b0, req_ready}, 32'd1);
    chk("R2 outputs", {31'b0, resp_done | resp_err}, 32'd0);
    chk("R2 rdata", resp_rdata | resp_preprog, 32'd0);
    rst_n = 1'b1;
    do_op(0, 0, '1, 0);                       // R2 even blank word
    do_op(0, 4, '1, 0);                       // R2 odd blank word
    do_op(1, 2, 32'hFFFF_FF0F, 0);            // R5 even burn
    do_op(1, 2, 32'hFFFF_F00F, 0);            // R5/R8 overlap flags 0xF0
    do_op(1, 3, 32'h0000_FFFF, 0);            // R6 odd burn
    do_op(1, 3, 32'hFF00_FFFF, 0);            // R8 odd flags
    do_op(1, 4, 32'hFFFF_FFFF, 0);            // R7 nothing selected
    do_op(1, 5, 32'h0000_0000, 0);            // R7 odd word equals inverted mask
    do_op(1, 2, ~32'h0000_0FF0, 0);           // R7 already burned
    do_op(0, 8, '1, 0);                       // R3 word 2 unchanged
    do_op(1, WORDS, 32'hFFFF_FFFE, 0);        // R9 index at end
    do_op(1, WORDS - 1, 32'hFFFF_FFFE, 0);    // R6 last word
    do_op(0, 4 * WORDS - 4, '1, 0);           // R3 last bytes
    do_op(0, 4 * WORDS - 3, '1, 0);           // R4 unaligned
    do_op(0, 4 * WORDS, '1, 0);               // R4 past end
    do_op(2, 8, '1, 32'h1234_5678);           // R10 load clears bits
    do_op(0, 8, '1, 0);                       // R10 read back
    do_op(2, 4 * WORDS, '1, 32'hDEAD_BEEF);   // R4 load out of range
    do_op(3, 0, '1, 0);                       // R12 reserved op
    do_op(0, 4 * (WORDS - 1), '1, 0);         // R4/R12 nothing changed
    for (int n = 0; n < 300; n++) begin
      int op = $urandom_range(0, 3);
      int a  = (op == 1) ? $urandom_range(0, WORDS + 1) : $urandom_range(0, 4 * WORDS + 5);
      logic [31:0] m = $urandom | $urandom;
      if (op == 3 && n % 3 != 0) op = 1;
      do_op(op, a, m, $urandom);
    end
    for (int i = 0; i < WORDS; i++) do_op(0, 4 * i, '1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule